// File: doc/BRIEF.md
# Loop Counter Branch Decision Unit

This unit makes the branch decision for a processor whose instruction words are 16 bits wide and byte addressed. For each branch-class instruction it takes the condition code bits, a 4-bit condition selector, the low 16 bits of a loop counter register, the byte address of the opcode word, the 8-bit offset field carried in the opcode and an optional 16-bit extension word. From these it produces a taken flag, the branch target, the next sequential PC and, for the loop form, a decremented counter value with a write strobe.

Three instruction kinds are handled:

- A conditional branch is taken when the selected condition holds.
- An unconditional branch is always taken.
- A decrement-and-branch loop instruction stops looping when its condition is true. Otherwise it counts the 16-bit counter down and branches back until the counter reaches all ones.

Branch displacements are signed and measured from the updated PC, which is the word right after the opcode. A zero 8-bit offset field selects a 16-bit displacement held in the extension word. In that case the sequential PC steps over the extension word.

The unit is issued one instruction per `issue` pulse. It presents registered results one cycle later, flagged by `res_valid`. Instruction fetch and register file access sit outside the block. The register file merges `cnt_out` into the low half of the counter register when `cnt_we` is high, so the upper half is never touched.

Top module: `loopbr_unit`

## Requirements
- R1: The updated PC is `op_addr + 2`. When `offset8` is non-zero, `target` equals the updated PC plus `offset8` sign-extended to 32 bits, giving a reach of -128 to +127 bytes. When `offset8` is non-zero, `seq_pc` equals `op_addr + 2`.
- R2: When `offset8` is zero, `target` equals `op_addr + 2` plus `ext_word` sign-extended to 32 bits, and `seq_pc` equals `op_addr + 4`. This rule applies to every kind.
- R3: Condition selector values are 0 true, 1 false, 2 HI (!C & !Z), 3 LS, 4 CC (!C), 5 CS, 6 NE (!Z), 7 EQ, 8 VC (!V), 9 VS, 10 PL (!N), 11 MI, 12 GE (N==V), 13 LT, 14 GT (!Z & N==V), 15 LE. The odd code of each pair is the inverse of the even code. Within `ccr`, bit 4 is X, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.
- R4: The X bit (`ccr[4]`) has no effect on any output.
- R5: For kind 0 (conditional branch), `taken` equals the selected condition and `cnt_we` stays low.
- R6: For kind 1 (decrement-and-branch), when the condition is true the result is not taken and `cnt_we` stays low.
- R7: For kind 1, when the condition is false, `cnt_we` is high and `cnt_out` equals `cnt_in - 1` modulo 2^16. In that case `taken` is high exactly when the decremented value is not 16'hFFFF.
- R8: For kind 2 (unconditional branch), `taken` is high regardless of the condition and `cnt_we` stays low.
- R9: Kind 3 is reserved: `taken` and `cnt_we` stay low.
- R10: Results appear at the first rising edge after an `issue` cycle, with `res_valid` high for exactly that one cycle. `cnt_we` is high only together with `res_valid`. After reset, `res_valid`, `cnt_we` and `taken` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Inputs hold a branch instruction this cycle |
| kind | input | 2 | 0 conditional, 1 decrement-and-branch, 2 unconditional, 3 reserved |
| cond_sel | input | 4 | Condition selector (see R3) |
| ccr | input | 5 | Condition bits {X,N,Z,V,C} |
| cnt_in | input | 16 | Low word of the counter register |
| op_addr | input | 32 | Byte address of the opcode word |
| offset8 | input | 8 | Offset field of the opcode |
| ext_word | input | 16 | Extension word after the opcode |
| res_valid | output | 1 | Result registers hold a new decision |
| taken | output | 1 | Branch to `target` |
| target | output | 32 | Branch target address |
| seq_pc | output | 32 | Address of the next sequential instruction |
| cnt_out | output | 16 | New low word of the counter |
| cnt_we | output | 1 | Write strobe for `cnt_out` |

## Verification
Every result of this block is due one rising edge after the `issue` cycle: `taken`, `target`, `seq_pc`, `cnt_out` and `cnt_we` all come from the same register stage. The bench drives an instruction on a falling edge and releases `issue` on the next falling edge. It samples all outputs at that second falling edge, half a period after the capturing edge. One falling edge later it confirms that `res_valid` and `cnt_we` have dropped, which shows the strobe lasts a single cycle.

// File: rtl/loopbr_pkg.sv
package loopbr_pkg;

  typedef enum logic [1:0] {
    KIND_BCC  = 2'b00,
    KIND_DBCC = 2'b01,
    KIND_BRA  = 2'b10,
    KIND_RSVD = 2'b11
  } br_kind_e;

  // Even codes are base conditions, odd codes their inverses.
  typedef enum logic [3:0] {
    CS_TRUE = 4'd0,  CS_FALSE = 4'd1,
    CS_HI   = 4'd2,  CS_LS    = 4'd3,
    CS_CC   = 4'd4,  CS_CS    = 4'd5,
    CS_NE   = 4'd6,  CS_EQ    = 4'd7,
    CS_VC   = 4'd8,  CS_VS    = 4'd9,
    CS_PL   = 4'd10, CS_MI    = 4'd11,
    CS_GE   = 4'd12, CS_LT    = 4'd13,
    CS_GT   = 4'd14, CS_LE    = 4'd15
  } cond_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam int unsigned NUM_BASE_COND = 8;

endpackage

// File: rtl/loopbr_cond_eval.sv
module loopbr_cond_eval
  import loopbr_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] sel,
  output logic       cond_true
);

  logic [NUM_BASE_COND-1:0] base;

  always_comb begin
    base[0] = 1'b1;
    base[1] = ~flags.c & ~flags.z;
    base[2] = ~flags.c;
    base[3] = ~flags.z;
    base[4] = ~flags.v;
    base[5] = ~flags.n;
    base[6] = ~(flags.n ^ flags.v);
    base[7] = ~flags.z & ~(flags.n ^ flags.v);
  end

  assign cond_true = base[sel[3:1]] ^ sel[0];

endmodule

// File: rtl/loopbr_target.sv
module loopbr_target #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SHORT_W    = 8,
  parameter int unsigned LONG_W     = 16,
  parameter int unsigned WORD_BYTES = 2
) (
  input  logic [ADDR_W-1:0]  op_addr,
  input  logic [SHORT_W-1:0] off_short,
  input  logic [LONG_W-1:0]  off_long,
  output logic [ADDR_W-1:0]  target,
  output logic [ADDR_W-1:0]  seq_pc
);

  localparam int unsigned SHORT_PAD = ADDR_W - SHORT_W;
  localparam int unsigned LONG_PAD  = ADDR_W - LONG_W;
  localparam logic [ADDR_W-1:0] ONE_WORD = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] TWO_WORD = ADDR_W'(2 * WORD_BYTES);

  logic              use_long;
  logic [ADDR_W-1:0] upd_pc;
  logic [ADDR_W-1:0] disp;

  always_comb begin
    use_long = (off_short == '0);
    upd_pc   = op_addr + ONE_WORD;
    if (use_long) begin
      disp   = {{LONG_PAD{off_long[LONG_W-1]}}, off_long};
      seq_pc = op_addr + TWO_WORD;
    end else begin
      disp   = {{SHORT_PAD{off_short[SHORT_W-1]}}, off_short};
      seq_pc = upd_pc;
    end
    target = upd_pc + disp;
  end

endmodule

// File: rtl/loopbr_counter.sv
module loopbr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_cur,
  output logic [CNT_W-1:0] cnt_dec,
  output logic             hit_end
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    cnt_dec = cnt_cur - ONE;
    hit_end = &cnt_dec;
  end

endmodule

// File: rtl/loopbr_unit.sv
module loopbr_unit
  import loopbr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned LONG_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [1:0]         kind,
  input  logic [3:0]         cond_sel,
  input  logic [4:0]         ccr,
  input  logic [CNT_W-1:0]   cnt_in,
  input  logic [ADDR_W-1:0]  op_addr,
  input  logic [SHORT_W-1:0] offset8,
  input  logic [LONG_W-1:0]  ext_word,
  output logic               res_valid,
  output logic               taken,
  output logic [ADDR_W-1:0]  target,
  output logic [ADDR_W-1:0]  seq_pc,
  output logic [CNT_W-1:0]   cnt_out,
  output logic               cnt_we
);

  localparam int unsigned SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  flags_t            flags;
  logic              cond_true;
  logic [ADDR_W-1:0] tgt_c;
  logic [ADDR_W-1:0] seq_c;
  logic [CNT_W-1:0]  dec_c;
  logic              end_c;

  assign flags = '{n: ccr[3], z: ccr[2], v: ccr[1], c: ccr[0]};

  loopbr_cond_eval u_cond (
    .flags     (flags),
    .sel       (cond_sel),
    .cond_true (cond_true)
  );

  loopbr_target #(
    .ADDR_W     (ADDR_W),
    .SHORT_W    (SHORT_W),
    .LONG_W     (LONG_W),
    .WORD_BYTES (2)
  ) u_tgt (
    .op_addr   (op_addr),
    .off_short (offset8),
    .off_long  (ext_word),
    .target    (tgt_c),
    .seq_pc    (seq_c)
  );

  loopbr_counter #(.CNT_W(CNT_W)) u_cnt (
    .cnt_cur (cnt_in),
    .cnt_dec (dec_c),
    .hit_end (end_c)
  );

  // Next-state decision
  logic             take_d;
  logic             we_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    take_d = 1'b0;
    we_d   = 1'b0;
    cnt_d  = cnt_in;
    unique case (br_kind_e'(kind))
      KIND_BCC:  take_d = cond_true;
      KIND_DBCC: begin
        if (!cond_true) begin
          we_d   = 1'b1;
          cnt_d  = dec_c;
          take_d = ~end_c;
        end
      end
      KIND_BRA:  take_d = 1'b1;
      default:   take_d = 1'b0;
    endcase
  end

  // Strobes: loaded every cycle
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_valid <= 1'b0;
      cnt_we    <= 1'b0;
    end else begin
      res_valid <= issue;
      cnt_we    <= issue & we_d;
    end
  end

  // Result data: loaded only on issue
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      taken   <= 1'b0;
      target  <= '0;
      seq_pc  <= '0;
      cnt_out <= '0;
    end else if (issue) begin
      taken   <= take_d;
      target  <= tgt_c;
      seq_pc  <= seq_c;
      cnt_out <= cnt_d;
    end
  end

endmodule

// File: rtl/loopbr_unit_chk.sv
module loopbr_unit_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned LONG_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               issue,
  input logic [1:0]         kind,
  input logic [CNT_W-1:0]   cnt_in,
  input logic [ADDR_W-1:0]  op_addr,
  input logic [SHORT_W-1:0] offset8,
  input logic               res_valid,
  input logic               taken,
  input logic [ADDR_W-1:0]  seq_pc,
  input logic [CNT_W-1:0]   cnt_out,
  input logic               cnt_we
);

  a_r10_we_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |-> res_valid);

  a_r10_valid_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(issue));

  a_r7_dec_value: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cnt_we) |-> (cnt_out == CNT_W'($past(cnt_in) - CNT_W'(1))));

  a_r7_no_branch_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cnt_we && taken) |-> (cnt_out != {CNT_W{1'b1}}));

  a_r2_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (seq_pc == ($past(offset8) == '0 ? $past(op_addr) + ADDR_W'(4)
                                                   : $past(op_addr) + ADDR_W'(2))));

  a_r8_bra_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(kind) == 2'b10) |-> (taken && !cnt_we));

  a_r9_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(kind) == 2'b11) |-> (!taken && !cnt_we));

endmodule

bind loopbr_unit loopbr_unit_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .kind(kind), .cnt_in(cnt_in),
  .op_addr(op_addr), .offset8(offset8), .res_valid(res_valid), .taken(taken),
  .seq_pc(seq_pc), .cnt_out(cnt_out), .cnt_we(cnt_we)
);

// File: tb/loopbr_unit_tb_top.sv
module loopbr_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        issue = 1'b0;
  logic [1:0]  kind = '0;
  logic [3:0]  cond_sel = '0;
  logic [4:0]  ccr = '0;
  logic [15:0] cnt_in = '0;
  logic [31:0] op_addr = '0;
  logic [7:0]  offset8 = '0;
  logic [15:0] ext_word = '0;
  logic        res_valid, taken, cnt_we;
  logic [31:0] target, seq_pc;
  logic [15:0] cnt_out;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loopbr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .kind(kind), .cond_sel(cond_sel),
    .ccr(ccr), .cnt_in(cnt_in), .op_addr(op_addr), .offset8(offset8),
    .ext_word(ext_word), .res_valid(res_valid), .taken(taken), .target(target),
    .seq_pc(seq_pc), .cnt_out(cnt_out), .cnt_we(cnt_we)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Condition truth from the R3 table; ccr = {X,N,Z,V,C}
  function automatic logic cond_ref(input logic [3:0] s, input logic [4:0] f);
    logic n, z, v, c, r;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (s)
      4'd0:  r = 1'b1;
      4'd1:  r = 1'b0;
      4'd2:  r = !c && !z;
      4'd3:  r = c || z;
      4'd4:  r = !c;
      4'd5:  r = c;
      4'd6:  r = !z;
      4'd7:  r = z;
      4'd8:  r = !v;
      4'd9:  r = v;
      4'd10: r = !n;
      4'd11: r = n;
      4'd12: r = (n == v);
      4'd13: r = (n != v);
      4'd14: r = !z && (n == v);
      default: r = z || (n != v);
    endcase
    return r;
  endfunction

  // Drive on a falling edge; results sampled at the following falling edge.
  task automatic run(input logic [1:0] k, input logic [3:0] s, input logic [4:0] f,
                     input logic [15:0] cnt, input logic [31:0] a,
                     input logic [7:0] o8, input logic [15:0] ext);
    kind = k; cond_sel = s; ccr = f; cnt_in = cnt;
    op_addr = a; offset8 = o8; ext_word = ext; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset res_valid", 32'(res_valid), 32'd0);
    chk("R10 reset cnt_we", 32'(cnt_we), 32'd0);
    chk("R10 reset taken", 32'(taken), 32'd0);
  endtask

  task automatic t_short_backward;
    run(2'd0, 4'd0, 5'b0, 16'd0, 32'h0000_1004, 8'hFA, 16'h7777);
    chk("R1 short backward target", target, 32'h0000_1000);
    chk("R1 short seq_pc", seq_pc, 32'h0000_1006);
    chk("R10 valid after issue", 32'(res_valid), 32'd1);
    chk("R5 always taken", 32'(taken), 32'd1);
    chk("R5 no write", 32'(cnt_we), 32'd0);
    @(negedge clk);
    chk("R10 valid one cycle", 32'(res_valid), 32'd0);
  endtask

  task automatic t_short_forward;
    run(2'd0, 4'd0, 5'b0, 16'd0, 32'h0000_2000, 8'h7F, 16'h0);
    chk("R1 short forward max", target, 32'h0000_2081);
  endtask

  task automatic t_long;
    run(2'd0, 4'd0, 5'b0, 16'd0, 32'h0001_0000, 8'h00, 16'h8000);
    chk("R2 long backward target", target, 32'h0000_8002);
    chk("R2 long seq_pc", seq_pc, 32'h0001_0004);
    run(2'd0, 4'd0, 5'b0, 16'd0, 32'h0000_0100, 8'h00, 16'h7FFE);
    chk("R2 long forward target", target, 32'h0000_8100);
  endtask

  task automatic t_cond_sweep;
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 16; f++) begin
        run(2'd0, 4'(s), {1'b0, 4'(f)}, 16'd0, 32'h400, 8'h10, 16'h0);
        chk($sformatf("R3 R5 sel=%0d flags=%0h", s, f), 32'(taken),
            32'(cond_ref(4'(s), {1'b0, 4'(f)})));
      end
    end
  endtask

  task automatic t_x_ignored;
    for (int s = 0; s < 16; s++) begin
      run(2'd0, 4'(s), 5'b1_0000, 16'd0, 32'h400, 8'h10, 16'h0);
      chk($sformatf("R4 X alone sel=%0d", s), 32'(taken), 32'(cond_ref(4'(s), 5'b0)));
    end
    run(2'd1, 4'd5, 5'b1_0000, 16'd3, 32'h400, 8'h10, 16'h0);
    chk("R4 X does not end loop", 32'(cnt_we), 32'd1);
  endtask

  task automatic t_dbcc;
    run(2'd1, 4'd7, 5'b0_0100, 16'd9, 32'h0000_1000, 8'hFC, 16'h0);
    chk("R6 cond true not taken", 32'(taken), 32'd0);
    chk("R6 cond true no write", 32'(cnt_we), 32'd0);
    chk("R6 seq_pc", seq_pc, 32'h0000_1002);
    run(2'd1, 4'd1, 5'b0, 16'd5, 32'h0000_1000, 8'hFC, 16'h0);
    chk("R7 count down value", 32'(cnt_out), 32'd4);
    chk("R7 count down write", 32'(cnt_we), 32'd1);
    chk("R7 loops back", 32'(taken), 32'd1);
    chk("R7 loop target", target, 32'h0000_0FFE);
    @(negedge clk);
    chk("R10 cnt_we one cycle", 32'(cnt_we), 32'd0);
    run(2'd1, 4'd1, 5'b0, 16'd0, 32'h0000_1000, 8'h00, 16'hFFF0);
    chk("R7 wrap value", 32'(cnt_out), 32'h0000_FFFF);
    chk("R7 wrap falls through", 32'(taken), 32'd0);
    chk("R7 wrap write", 32'(cnt_we), 32'd1);
    chk("R2 dbcc long seq_pc", seq_pc, 32'h0000_1004);
    run(2'd1, 4'd1, 5'b0, 16'd1, 32'h0000_1000, 8'hFC, 16'h0);
    chk("R7 reach zero still loops", 32'(taken), 32'd1);
    chk("R7 reach zero value", 32'(cnt_out), 32'd0);
  endtask

  task automatic t_bra_rsvd;
    run(2'd2, 4'd1, 5'b0, 16'd7, 32'h0000_3000, 8'h20, 16'h0);
    chk("R8 unconditional taken", 32'(taken), 32'd1);
    chk("R8 unconditional no write", 32'(cnt_we), 32'd0);
    chk("R8 target", target, 32'h0000_3022);
    run(2'd3, 4'd0, 5'b0, 16'd7, 32'h0000_3000, 8'h20, 16'h0);
    chk("R9 reserved not taken", 32'(taken), 32'd0);
    chk("R9 reserved no write", 32'(cnt_we), 32'd0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_short_backward();
    t_short_forward();
    t_long();
    t_cond_sweep();
    t_x_ignored();
    t_dbcc();
    t_bra_rsvd();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule